// File: doc/BRIEF.md
# Two-Phase Hybrid Scan Test Sequencer

This block sequences a scan test session in two phases. In the first phase it loads a programmed number of vectors through a tree-organised scan path. A tree path fills in only ceil(log2 f) shift cycles for f flip-flops. After each load the block drops into functional mode for a programmed number of clocks. In those clocks the captured response is fed back as the next vector, and a 16-bit LFSR supplies pseudo-random values to the primary inputs. In the second phase it loads a smaller programmed number of vectors through the ordinary linear chain of f cycles, again with a circulation burst after each load. When the last linear burst ends, it raises a one-cycle completion pulse.

The block drives three things. A shift-enable strobe runs the slow scan shifting. A select picks between tree and linear scan wiring. A functional-enable strobe marks the at-speed circulation clocks. The vector counts, the burst length and the LFSR seed are captured on the start request. They can change freely while a session runs.

Top module: `hybrid_scan_seq`

## Requirements
- R1: After reset `shiftEn`, `treeSel`, `funcEn` and `done` are 0 and `lfsrPat` is 16'h0001; the same idle outputs hold whenever no session runs.
- R2: A `start` seen in the idle state captures `treeVecs`, `linVecs`, `circLen` and `seed` at that edge. Later changes of those inputs, and `start` while a session runs or while `done` is high, have no effect on the outputs.
- R3: In the tree phase each of the `treeVecs` vectors begins with TREE_LEN = ceil(log2 NUM_FF) cycles (at least 1) with `shiftEn`=1, `treeSel`=1, `funcEn`=0.
- R4: Each shift is followed by exactly `circLen` cycles with `funcEn`=1 and `shiftEn`=0, with `treeSel` still showing the phase. When `circLen` is 0 the next shift follows at once.
- R5: In the linear phase each of the `linVecs` vectors begins with NUM_FF cycles with `shiftEn`=1, `treeSel`=0, followed by its circulation burst as in R4.
- R6: The LFSR shifts left with the new bit entering bit 0. That bit is the XOR of bits 15, 13, 12 and 10. It advances exactly once per cycle with `funcEn`=1 and holds otherwise. It carries on across vectors and phases, and `lfsrPat` shows its current state.
- R7: A start with `seed` equal to 0 loads 16'h0001 instead. Any other seed loads unchanged, and `lfsrPat` shows the loaded seed from the cycle after start.
- R8: A zero `treeVecs` skips the tree phase and a zero `linVecs` skips the linear phase. If both are zero, `done` follows start directly.
- R9: `done` is high for exactly one cycle, immediately after the last cycle of the final phase, and the block is idle the cycle after.
- R10: `shiftEn` and `funcEn` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Session start request, honoured in idle |
| treeVecs | input | VEC_W | Number of tree-phase vectors |
| linVecs | input | VEC_W | Number of linear-phase vectors |
| circLen | input | CIRC_W | Circulation clocks after each vector |
| seed | input | 16 | LFSR seed |
| shiftEn | output | 1 | Scan shift enable |
| treeSel | output | 1 | 1 selects tree scan wiring (tree phase) |
| funcEn | output | 1 | Functional-mode circulation clock enable |
| lfsrPat | output | 16 | Pseudo-random primary-input pattern |
| done | output | 1 | One-cycle session completion pulse |

## Verification
The bench builds the block with NUM_FF=10, VEC_W=6 and CIRC_W=8. With these values a tree load takes 4 cycles and a linear load takes 10. The two phases can then be told apart from `shiftEn` alone, and a whole session fits in a few dozen cycles. A behavioural queue model predicts every output cycle by cycle. The sessions cover both phases together, zero-length bursts, each phase skipped, both skipped, a zero seed, and start pulses during a run.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  localparam int LFSR_W = 16;

  typedef enum logic [2:0] {
    S_IDLE       = 3'd0,
    S_TREE_SHIFT = 3'd1,
    S_TREE_CIRC  = 3'd2,
    S_LIN_SHIFT  = 3'd3,
    S_LIN_CIRC   = 3'd4,
    S_DONE       = 3'd5
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cfgLoad;
    logic cycClr;
    logic vecClr;
    logic vecInc;
    logic lfsrStep;
    logic treeMode;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic shiftDone;
    logic circDone;
    logic circNone;
    logic vecLast;
    logic treeNone;
    logic linNone;
  } dpStatus_t;

endpackage

// File: rtl/hsc_datapath.sv
module hsc_datapath
  import hsc_pkg::*;
#(
  parameter int NUM_FF = 16,
  parameter int VEC_W  = 8,
  parameter int CIRC_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic [VEC_W-1:0]   treeVecsIn,
  input  logic [VEC_W-1:0]   linVecsIn,
  input  logic [CIRC_W-1:0]  circLenIn,
  input  logic [LFSR_W-1:0]  seedIn,
  output dpStatus_t          stat,
  output logic [LFSR_W-1:0]  lfsrPat
);

  localparam int TREE_LEN = (NUM_FF < 2) ? 1 : $clog2(NUM_FF);
  localparam int LIN_LEN  = NUM_FF;
  localparam int LEN_W    = $clog2(NUM_FF + 1);
  localparam int CYC_W    = (LEN_W > CIRC_W) ? LEN_W : CIRC_W;
  localparam logic [CYC_W-1:0] TREE_LAST = CYC_W'(TREE_LEN - 1);
  localparam logic [CYC_W-1:0] LIN_LAST  = CYC_W'(LIN_LEN - 1);

  logic [VEC_W-1:0]  treeVecsQ, linVecsQ, vecCnt, vecLimit;
  logic [CIRC_W-1:0] circLenQ;
  logic [CYC_W-1:0]  cycCnt, circLast;
  logic [LFSR_W-1:0] lfsrQ, lfsrNext, seedSafe;
  logic              feedback;

  // configuration capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      treeVecsQ <= '0;
      linVecsQ  <= '0;
      circLenQ  <= '0;
    end else if (strb.cfgLoad) begin
      treeVecsQ <= treeVecsIn;
      linVecsQ  <= linVecsIn;
      circLenQ  <= circLenIn;
    end
  end

  // per-phase cycle counter
  always_ff @(posedge clk) begin
    if (!rstN)            cycCnt <= '0;
    else if (strb.cycClr) cycCnt <= '0;
    else                  cycCnt <= cycCnt + 1'b1;
  end

  // vector counter within the current phase
  always_ff @(posedge clk) begin
    if (!rstN)            vecCnt <= '0;
    else if (strb.vecClr) vecCnt <= '0;
    else if (strb.vecInc) vecCnt <= vecCnt + 1'b1;
  end

  // pattern generator
  assign feedback = lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10];
  assign lfsrNext = {lfsrQ[LFSR_W-2:0], feedback};
  assign seedSafe = (seedIn == '0) ? LFSR_W'(1) : seedIn;

  always_ff @(posedge clk) begin
    if (!rstN)              lfsrQ <= LFSR_W'(1);
    else if (strb.cfgLoad)  lfsrQ <= seedSafe;
    else if (strb.lfsrStep) lfsrQ <= lfsrNext;
  end

  assign lfsrPat = lfsrQ;

  // status
  assign vecLimit = strb.treeMode ? treeVecsQ : linVecsQ;
  assign circLast = CYC_W'(circLenQ) - 1'b1;

  always_comb begin
    stat           = '0;
    stat.shiftDone = (cycCnt == (strb.treeMode ? TREE_LAST : LIN_LAST));
    stat.circDone  = (cycCnt == circLast);
    stat.circNone  = (circLenQ == '0);
    stat.vecLast   = (vecCnt == vecLimit - 1'b1);
    stat.treeNone  = ((strb.cfgLoad ? treeVecsIn : treeVecsQ) == '0);
    stat.linNone   = ((strb.cfgLoad ? linVecsIn  : linVecsQ)  == '0);
  end

  // assertions guarding the generator
  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
  p_lfsr_moves_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.lfsrStep && !strb.cfgLoad |=> lfsrQ != $past(lfsrQ));
  p_lfsr_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lfsrStep && !strb.cfgLoad |=> $stable(lfsrQ));
  p_zero_seed_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.cfgLoad && seedIn == '0 |=> lfsrQ == LFSR_W'(1));

endmodule

// File: rtl/hsc_control.sv
module hsc_control
  import hsc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   stat,
  output ctrlStrobe_t strb,
  output logic        shiftEn,
  output logic        treeSel,
  output logic        funcEn,
  output logic        done
);

  seqState_e state, nxt;
  logic      endVec, inTree;

  assign inTree = (state == S_TREE_SHIFT) || (state == S_TREE_CIRC);

  always_comb begin
    nxt           = state;
    strb          = '0;
    strb.treeMode = inTree;
    endVec        = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.cfgLoad = 1'b1;
          strb.cycClr  = 1'b1;
          strb.vecClr  = 1'b1;
          if (!stat.treeNone)     nxt = S_TREE_SHIFT;
          else if (!stat.linNone) nxt = S_LIN_SHIFT;
          else                    nxt = S_DONE;
        end
      end
      S_TREE_SHIFT, S_LIN_SHIFT: begin
        if (stat.shiftDone) begin
          strb.cycClr = 1'b1;
          if (stat.circNone) endVec = 1'b1;
          else nxt = inTree ? S_TREE_CIRC : S_LIN_CIRC;
        end
      end
      S_TREE_CIRC, S_LIN_CIRC: begin
        strb.lfsrStep = 1'b1;
        if (stat.circDone) begin
          strb.cycClr = 1'b1;
          endVec      = 1'b1;
        end
      end
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase

    if (endVec) begin
      strb.vecInc = 1'b1;
      if (stat.vecLast) begin
        strb.vecClr = 1'b1;
        if (inTree && !stat.linNone) nxt = S_LIN_SHIFT;
        else                         nxt = S_DONE;
      end else begin
        nxt = inTree ? S_TREE_SHIFT : S_LIN_SHIFT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  assign shiftEn = (state == S_TREE_SHIFT) || (state == S_LIN_SHIFT);
  assign funcEn  = (state == S_TREE_CIRC)  || (state == S_LIN_CIRC);
  assign treeSel = inTree;
  assign done    = (state == S_DONE);

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftEn && funcEn));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && state == S_IDLE);
  p_busy_ignores_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    (shiftEn || funcEn) |=> state != S_IDLE);
  p_shift_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == S_TREE_SHIFT && !stat.shiftDone |=> state == S_TREE_SHIFT);
  p_lin_after_tree_r5: assert property (@(posedge clk) disable iff (!rstN)
    state == S_LIN_SHIFT |=> state != S_TREE_SHIFT && state != S_TREE_CIRC);

endmodule

// File: rtl/hybrid_scan_seq.sv
module hybrid_scan_seq
  import hsc_pkg::*;
#(
  parameter int NUM_FF = 16,
  parameter int VEC_W  = 8,
  parameter int CIRC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [VEC_W-1:0]  treeVecs,
  input  logic [VEC_W-1:0]  linVecs,
  input  logic [CIRC_W-1:0] circLen,
  input  logic [15:0]       seed,
  output logic              shiftEn,
  output logic              treeSel,
  output logic              funcEn,
  output logic [15:0]       lfsrPat,
  output logic              done
);

  ctrlStrobe_t strb;
  dpStatus_t   stat;

  hsc_control ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .stat    (stat),
    .strb    (strb),
    .shiftEn (shiftEn),
    .treeSel (treeSel),
    .funcEn  (funcEn),
    .done    (done)
  );

  hsc_datapath #(
    .NUM_FF (NUM_FF),
    .VEC_W  (VEC_W),
    .CIRC_W (CIRC_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .treeVecsIn (treeVecs),
    .linVecsIn  (linVecs),
    .circLenIn  (circLen),
    .seedIn     (seed),
    .stat       (stat),
    .lfsrPat    (lfsrPat)
  );

endmodule

// File: tb/hybrid_scan_seq_tb_top.sv
module hybrid_scan_seq_tb_top;

  localparam int NUM_FF   = 10;
  localparam int VEC_W    = 6;
  localparam int CIRC_W   = 8;
  localparam int TREE_LEN = 4;   // ceil(log2 10)
  localparam int LIN_LEN  = 10;

  logic              clk = 1'b0;
  logic              rstN;
  logic              start;
  logic [VEC_W-1:0]  treeVecs, linVecs;
  logic [CIRC_W-1:0] circLen;
  logic [15:0]       seed;
  logic              shiftEn, treeSel, funcEn, done;
  logic [15:0]       lfsrPat;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  // expected entry: {shiftEn, treeSel, funcEn, done, lfsr}
  logic [19:0] expQ[$];
  logic [15:0] modelLfsr;

  always #4 clk = ~clk;  // 125 MHz

  hybrid_scan_seq #(.NUM_FF(NUM_FF), .VEC_W(VEC_W), .CIRC_W(CIRC_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .treeVecs(treeVecs),
    .linVecs(linVecs), .circLen(circLen), .seed(seed), .shiftEn(shiftEn),
    .treeSel(treeSel), .funcEn(funcEn), .lfsrPat(lfsrPat), .done(done)
  );

  function automatic logic [15:0] advance(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  // Build the expected output stream of a whole session (R3 R4 R5 R6 R7 R8 R9)
  task automatic plan(input int t, input int l, input int c, input logic [15:0] s);
    logic [15:0] x;
    x = (s == 16'h0) ? 16'h0001 : s;
    for (int v = 0; v < t; v++) begin
      for (int k = 0; k < TREE_LEN; k++) expQ.push_back({4'b1100, x});
      for (int k = 0; k < c; k++) begin
        expQ.push_back({4'b0110, x});
        x = advance(x);
      end
    end
    for (int v = 0; v < l; v++) begin
      for (int k = 0; k < LIN_LEN; k++) expQ.push_back({4'b1000, x});
      for (int k = 0; k < c; k++) begin
        expQ.push_back({4'b0010, x});
        x = advance(x);
      end
    end
    expQ.push_back({4'b0001, x});
    modelLfsr = x;
  endtask

  function automatic string tagOf(input logic [19:0] e, input logic [19:0] a);
    if (e[15:0] != a[15:0]) return "R6/R7";
    if (e[16])              return "R9";
    if (e[17])              return "R4";
    if (e[19] && e[18])     return "R3";
    if (e[19])              return "R5";
    return "R1/R2/R8";
  endfunction

  // one clock: compare current outputs, then drive start for the next edge
  task automatic step(input logic startV, input logic [15:0] seedV,
                      input int t, input int l, input int c);
    logic [19:0] exp, act;
    bit          wasIdle;
    @(negedge clk);
    wasIdle = (expQ.size() == 0);
    exp = wasIdle ? {4'b0000, modelLfsr} : expQ.pop_front();
    act = {shiftEn, treeSel, funcEn, done, lfsrPat};
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h at %0t", tagOf(exp, act), act, exp, $time);
    end
    compared++;  // R10
    if (shiftEn && funcEn) begin
      mismatched++;
      $display("FAIL R10: shiftEn=%b funcEn=%b expected not both", shiftEn, funcEn);
    end
    start = startV;
    if (startV && wasIdle) begin
      treeVecs = VEC_W'(t);
      linVecs  = VEC_W'(l);
      circLen  = CIRC_W'(c);
      seed     = seedV;
      plan(t, l, c, seedV);
    end
  endtask

  task automatic session(input int t, input int l, input int c, input logic [15:0] s);
    int i = 0;
    step(1'b1, s, t, l, c);
    // scramble config after capture (R2: must be ignored)
    step(1'b0, 16'h0, 0, 0, 0);
    treeVecs = '1; linVecs = '1; circLen = 8'd3; seed = 16'h5555;
    while (expQ.size() > 0) begin
      // start pulses while busy (R2: ignored)
      step((i % 7) == 3, 16'h1234, 9, 9, 9);
      i++;
    end
    step(1'b0, 16'h0, 0, 0, 0);
    step(1'b0, 16'h0, 0, 0, 0);
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; treeVecs = '0; linVecs = '0; circLen = '0; seed = '0;
    modelLfsr = 16'h0001;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 16'h0, 0, 0, 0);                 // R1 reset state
    step(1'b0, 16'h0, 0, 0, 0);
    session(3, 2, 5, 16'hACE1);                 // both phases, R3 R4 R5 R6 R9
    session(2, 1, 0, 16'h00F0);                 // zero burst, R4
    session(0, 2, 3, 16'h8001);                 // tree phase skipped, R8
    session(2, 0, 2, 16'h7777);                 // linear phase skipped, R8
    session(0, 0, 4, 16'h4242);                 // both skipped, R8 R9
    session(1, 1, 6, 16'h0000);                 // zero seed, R7
    session(4, 3, 1, 16'hFFFF);                 // long run across phases, R6
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule